// File: doc/BRIEF.md
# Flash Power-Mode Sequencer

This block drives the power mode of an embedded flash bank and its charge pump. There are three modes: sleep, standby, and active (read). The requested mode is a level input. Steps up in power go through timed waits, and each kind of step has its own programmable wait counter. A step down in power takes effect on the next clock. A request from sleep to active always passes through standby on the way.

A 16-bit status word reports four things:

- the current mode;
- which of the two wait counters is running;
- a sticky flag for a pump supply fault;
- zeros in every other bit.

The fault flag is cleared by writing a 1 to it through a simple write port. Two enable outputs follow the reported mode: one turns on the pump and one allows bank reads.

Top module: `flash_pwr_seq`

## Requirements
- R1: The status mode field is bits 1:0. It reads 00 for sleep, 01 for standby and 11 for active, and never reads 10. Bits 15:9 and 7:4 always read 0. Reset clears the whole status word and both enables, so the block reports sleep after reset.
- R2: Suppose a request for a higher-power mode is first sampled at clock edge k and the sleep-to-standby wait value is N. The mode field does not change before the wait expires. It changes to 01 just after edge k+N+1.
- R3: Status bit 2 reads 1 while the sleep-to-standby counter runs, which is from edge k through edge k+N, so N+1 cycles. It reads 0 at all other times.
- R4: Status bit 3 reads 1 while the standby-to-active counter runs, and 0 otherwise. Bits 2 and 3 are never 1 together.
- R5: A sleep-to-active request runs the sleep-to-standby counter first. The standby-to-active counter, with wait value M, is loaded on the same edge that the mode becomes 01. The mode then reads 01 for M+1 cycles before it reads 11.
- R6: A request for a lower-power mode sampled at edge k sets the mode field to that mode just after edge k. It also stops any counter that is running.
- R7: A change of request while a count is running cancels that count. A lower target applies at once, as in R6. A different higher target reloads the counter, so the wait starts over from the edge that sampled the change.
- R8: A wait value of 0 completes a step in one cycle: the busy bit reads 1 for one cycle and the mode advances on the next edge.
- R9: Status bit 8 sets on the edge after the supply-fault input is sampled high, and stays set after the input returns low. Writing bit 8 as 1 clears it. Writing bit 8 as 0 leaves it unchanged. If a set and a clear happen on the same edge, the bit stays set.
- R10: Writes have no effect on the mode field, the busy bits or the zero bits.
- R11: pump_on_o is 1 whenever the mode is not sleep. bank_rd_o is 1 only when the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_mode_i | input | 2 | Requested mode, level: 00 sleep, 01 standby, 11 active |
| stby_wait_i | input | CNT_W | Wait count for the sleep-to-standby step |
| act_wait_i | input | CNT_W | Wait count for the standby-to-active step |
| vfault_i | input | 1 | Supply-fault signal from the pump |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 16 | Status write data; only bit 8 (write 1 to clear) has an effect |
| status_o | output | 16 | Status word |
| pump_on_o | output | 1 | Charge pump enable |
| bank_rd_o | output | 1 | Bank read enable |

## Verification
The assertions assume three things about the inputs:

- the requested mode never takes the reserved code 10;
- the wait values stay stable while a count runs;
- the fault input and the write port are synchronous to the clock.

The stimulus keeps to these assumptions. It changes every input only on the falling edge. It uses only the three legal mode codes. It loads new wait values only while no counter is busy. Write pulses last one cycle each, and several of them also set other status bits to 1, to show that those bits ignore writes.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_STBY  = 2'b01,
    MODE_ACT   = 2'b11
  } pwr_mode_e;

  localparam int unsigned STAT_W     = 16;
  localparam int unsigned N_STEPS    = 2;
  localparam int unsigned STEP_S2B   = 0;
  localparam int unsigned STEP_B2A   = 1;
  localparam int unsigned BIT_S2B    = 2;
  localparam int unsigned BIT_B2A    = 3;
  localparam int unsigned BIT_FAULT  = 8;
endpackage

// File: rtl/flash_wait_ctr.sv
module flash_wait_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_i;
      busy_q <= 1'b1;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R8
  zero_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && load_i == '0) |=> done_o);
  // R3
  keep_counting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !start_i && !cancel_i) |=> busy_o);
endmodule

// File: rtl/flash_fault_latch.sv
module flash_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  logic fault_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= set_i | (fault_q & ~clr_i);
  end

  assign fault_o = fault_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> fault_o);
  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr_i) |=> fault_o);
  // R9
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && !set_i) |=> !fault_o);
endmodule

// File: rtl/flash_pwr_fsm.sv
module flash_pwr_fsm
  import flash_pwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         req_mode_i,
  input  logic [N_STEPS-1:0] busy_i,
  input  logic [N_STEPS-1:0] done_i,
  output logic [N_STEPS-1:0] start_o,
  output logic               cancel_o,
  output pwr_mode_e          mode_o
);
  pwr_mode_e mode_q, mode_d, tgt, tgt_q;
  logic      step;

  assign tgt  = req_mode_i[1] ? MODE_ACT : (req_mode_i[0] ? MODE_STBY : MODE_SLEEP);
  assign step = (mode_q != MODE_SLEEP);

  always_comb begin
    mode_d   = mode_q;
    start_o  = '0;
    cancel_o = 1'b0;
    if (tgt < mode_q) begin
      mode_d   = tgt;
      cancel_o = 1'b1;
    end else if (tgt == mode_q) begin
      cancel_o = 1'b1;
    end else if (tgt != tgt_q) begin
      cancel_o      = 1'b1;
      start_o[step] = 1'b1;
    end else if (done_i[STEP_S2B]) begin
      mode_d = MODE_STBY;
      if (tgt == MODE_ACT) start_o[STEP_B2A] = 1'b1;
    end else if (done_i[STEP_B2A]) begin
      mode_d = MODE_ACT;
    end else if (busy_i == '0) begin
      start_o[step] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLEEP;
      tgt_q  <= MODE_SLEEP;
    end else begin
      mode_q <= mode_d;
      tgt_q  <= tgt;
    end
  end

  assign mode_o = mode_q;

  // R1
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b10);
  // R2
  s2b_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && !done_i[STEP_S2B]) |=> mode_q != MODE_STBY);
  // R2
  b2a_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STBY && !done_i[STEP_B2A]) |=> mode_q != MODE_ACT);
  // R5
  via_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP) |=> mode_q != MODE_ACT);
  // R6
  drop_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_mode_i == 2'b00) |=> mode_q == MODE_SLEEP);
  // R6
  drop_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_mode_i == 2'b01 && mode_q == MODE_ACT) |=> mode_q == MODE_STBY);
endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq
  import flash_pwr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        req_mode_i,
  input  logic [CNT_W-1:0]  stby_wait_i,
  input  logic [CNT_W-1:0]  act_wait_i,
  input  logic              vfault_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              pump_on_o,
  output logic              bank_rd_o
);
  logic [N_STEPS-1:0] start, busy, done;
  logic [CNT_W-1:0]   load [N_STEPS];
  logic               cancel, fault, unused_wr;
  pwr_mode_e          mode;

  assign load[STEP_S2B] = stby_wait_i;
  assign load[STEP_B2A] = act_wait_i;
  assign unused_wr = ^{wr_data_i[STAT_W-1:BIT_FAULT+1], wr_data_i[BIT_FAULT-1:0]};

  flash_pwr_fsm u_fsm (
    .clk_i, .rst_ni, .req_mode_i,
    .busy_i(busy), .done_i(done),
    .start_o(start), .cancel_o(cancel), .mode_o(mode)
  );

  for (genvar g = 0; g < N_STEPS; g++) begin : g_ctr
    flash_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i, .rst_ni,
      .start_i(start[g]), .cancel_i(cancel), .load_i(load[g]),
      .busy_o(busy[g]), .done_o(done[g])
    );
  end

  flash_fault_latch u_fault (
    .clk_i, .rst_ni,
    .set_i(vfault_i), .clr_i(wr_en_i & wr_data_i[BIT_FAULT]),
    .fault_o(fault)
  );

  always_comb begin
    status_o            = '0;
    status_o[1:0]       = mode;
    status_o[BIT_S2B]   = busy[STEP_S2B];
    status_o[BIT_B2A]   = busy[STEP_B2A];
    status_o[BIT_FAULT] = fault;
  end

  assign pump_on_o = (mode != MODE_SLEEP);
  assign bank_rd_o = (mode == MODE_ACT);

  // R4
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy));
  // R11
  enable_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_rd_o |-> pump_on_o);
endmodule

// File: tb/flash_pwr_seq_bench.sv
`timescale 1ns/1ps
module flash_pwr_seq_bench;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       req_mode_i = 2'b00;
  logic [CNT_W-1:0] stby_wait_i = '0;
  logic [CNT_W-1:0] act_wait_i = '0;
  logic             vfault_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [15:0]      wr_data_i = '0;
  logic [15:0]      status_o;
  logic             pump_on_o, bank_rd_o;

  flash_pwr_seq #(.CNT_W(CNT_W)) u_flash_pwr_seq (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    int          cyc;
    logic [17:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  item_t it;
  int    cyc_n = 0;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc_n <= 0;
    else         cyc_n <= cyc_n + 1;

  function automatic logic [17:0] ew(logic bank, logic pump, logic flt,
                                     logic b3, logic b2, logic [1:0] md);
    return {bank, pump, 7'b0, flt, 4'b0, b3, b2, md};
  endfunction

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations due this cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      while (q.size() > 0 && q[0].cyc <= cyc_n) begin
        it = q.pop_front();
        if (it.cyc < cyc_n) chk({it.tag, " stale"}, 18'h3ffff, it.val);
        else chk(it.tag, {bank_rd_o, pump_on_o, status_o}, it.val);
      end
    end
  end

  task automatic push(int cyc, logic [17:0] val, string tag);
    item_t n;
    n.cyc = cyc; n.val = val; n.tag = tag;
    q.push_back(n);
  endtask

  task automatic wait_until(int t);
    while (cyc_n < t) @(negedge clk_i);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr_pulse(logic [15:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, k2;
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", {bank_rd_o, pump_on_o, status_o}, 18'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R5 R11: sleep to active, N=3, M=2
    stby_wait_i = 8'd3; act_wait_i = 8'd2;
    req_mode_i = 2'b11; k = cyc_n + 1;
    push(k,     ew(0,0,0,0,1,2'b00), "R3 s2b busy at start");
    push(k+3,   ew(0,0,0,0,1,2'b00), "R2 still sleep at last count");
    push(k+4,   ew(0,1,0,1,0,2'b01), "R5 standby with b2a loaded");
    push(k+6,   ew(0,1,0,1,0,2'b01), "R5 standby held M+1 cycles");
    push(k+7,   ew(1,1,0,0,0,2'b11), "R11 active enables");
    drain();

    // R10: write all ones except fault bit while active
    wr_pulse(16'hFEFF);
    chk("R10 write ignored", {bank_rd_o, pump_on_o, status_o}, ew(1,1,0,0,0,2'b11));

    // R6: downward steps
    req_mode_i = 2'b01; k = cyc_n + 1;
    push(k, ew(0,1,0,0,0,2'b01), "R6 active to standby");
    drain();
    req_mode_i = 2'b00; k = cyc_n + 1;
    push(k, ew(0,0,0,0,0,2'b00), "R6 standby to sleep");
    drain();

    // R8: zero waits
    stby_wait_i = 8'd0; act_wait_i = 8'd0;
    req_mode_i = 2'b11; k = cyc_n + 1;
    push(k,   ew(0,0,0,0,1,2'b00), "R8 s2b one cycle");
    push(k+1, ew(0,1,0,1,0,2'b01), "R8 b2a one cycle");
    push(k+2, ew(1,1,0,0,0,2'b11), "R8 active");
    drain();
    req_mode_i = 2'b00;
    drain();

    // R7: cancel downward during b2a count
    stby_wait_i = 8'd1; act_wait_i = 8'd10;
    req_mode_i = 2'b11; k = cyc_n + 1;
    push(k+2, ew(0,1,0,1,0,2'b01), "R4 b2a busy in standby");
    drain();
    wait_until(k + 4);
    req_mode_i = 2'b00; k2 = cyc_n + 1;
    push(k2,   ew(0,0,0,0,0,2'b00), "R7 cancel to sleep");
    push(k2+5, ew(0,0,0,0,0,2'b00), "R7 stays sleep idle");
    drain();

    // R7: retarget restarts s2b count
    stby_wait_i = 8'd6;
    req_mode_i = 2'b11; k = cyc_n + 1;
    wait_until(k + 2);
    req_mode_i = 2'b01; k2 = cyc_n + 1;
    push(k2+4, ew(0,0,0,0,1,2'b00), "R7 count reloaded");
    push(k2+6, ew(0,0,0,0,1,2'b00), "R7 last reloaded count");
    push(k2+7, ew(0,1,0,0,0,2'b01), "R7 standby after reload");
    drain();
    req_mode_i = 2'b00;
    drain();

    // R9: fault latch
    vfault_i = 1'b1; k = cyc_n + 1;
    @(negedge clk_i);
    vfault_i = 1'b0;
    push(k+3, ew(0,0,1,0,0,2'b00), "R9 fault sticky");
    drain();
    wr_pulse(16'hFEFF);
    chk("R9 write zero ignored", {bank_rd_o, pump_on_o, status_o}, ew(0,0,1,0,0,2'b00));
    wr_pulse(16'h0100);
    chk("R9 write one clears", {bank_rd_o, pump_on_o, status_o}, ew(0,0,0,0,0,2'b00));
    vfault_i = 1'b1;
    wr_pulse(16'h0100);
    vfault_i = 1'b0;
    chk("R9 set beats clear", {bank_rd_o, pump_on_o, status_o}, ew(0,0,1,0,0,2'b00));
    wr_pulse(16'hFFFF);
    chk("R10 clear leaves others", {bank_rd_o, pump_on_o, status_o}, ew(0,0,0,0,0,2'b00));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule